// File: doc/BRIEF.md
# Smith-Waterman Systolic Cell with Ping-Pong Score Columns

This block is one processing element of a linear systolic array that computes local protein alignment scores. For the current pass, the cell holds one query residue and the substitution-score column that belongs to it. Subject residues arrive one per cycle, each paired with the score that the upstream cell produced for that residue. The cell combines three values: the upstream score from the previous cycle (the diagonal), the upstream score for the current residue (up), and its own previous result (left). It applies the substitution score and a linear gap penalty, then forwards the residue and its new score downstream one cycle later. It also keeps the highest score seen so far in the pass.

The cell has two substitution-column banks. One bank serves the running pass. The configuration port writes only the other bank, so the column for the next fold can be loaded while the array is still computing. A single `pass_start` pulse swaps the bank roles and promotes a staged query residue. The same pulse clears the per-pass state, so no stall cycles are needed between folds.

Residues use a 5-bit code and only codes 0 to 23 are real symbols. Substitution scores are signed 8-bit values. Cell scores are unsigned 16-bit values.

Top module: `sw_cell`

## Requirements
- R1: After reset, `out_valid`, `out_score`, `best_score`, `active_bank` and `query_res` are all 0.
- R2: For an accepted residue, the new score is the largest of four terms: 0, diagonal plus substitution score, up minus `gap_pen`, and left minus `gap_pen`. A subtraction that would go below zero gives 0.
- R3: The substitution score is read from the active bank at address `in_res`. Residue codes 24 to 31 read a substitution score of 0.
- R4: The diagonal-plus-substitution term saturates at 65535 and never wraps.
- R5: A residue accepted on one clock edge appears on `out_res`, together with its score on `out_score` and `out_valid` = 1, right after that edge. The latency is exactly one cycle.
- R6: The left term is the cell's own score for the previous accepted residue. The diagonal term is `in_score` of the previous accepted residue. Both are 0 for the first residue after `pass_start`.
- R7: A cycle with `in_valid` = 0 and no `pass_start` leaves the score, residue, left, diagonal and best registers unchanged, and it drives `out_valid` to 0.
- R8: A write (`cfg_we`, `cfg_addr`, `cfg_data`) updates only the bank that is inactive on that clock edge. It never changes the scores of the running pass. Addresses 24 to 31 are ignored.
- R9: `pass_start` toggles `active_bank`. It copies the staged query residue (written through `qry_we`/`qry_in`) to `query_res`. It clears left, diagonal and `best_score`. It drops any residue offered in the same cycle, so `out_valid` is 0 in the following cycle.
- R10: `best_score` equals the maximum `out_score` produced since the last `pass_start` or reset.
- R11: `gap_pen` is a run-time input. It is applied in each cycle as the value present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pass_start | input | 1 | Pass boundary pulse: swaps banks and clears pass state |
| gap_pen | input | 8 | Linear gap penalty, unsigned |
| qry_we | input | 1 | Writes the staged query residue |
| qry_in | input | 5 | Query residue for the next pass |
| cfg_we | input | 1 | Write strobe for the inactive score bank |
| cfg_addr | input | 5 | Residue code to write in the inactive bank |
| cfg_data | input | 8 | Signed substitution score |
| in_valid | input | 1 | Subject residue and upstream score are valid |
| in_res | input | 5 | Subject residue code |
| in_score | input | 16 | Upstream cell score for this residue |
| out_valid | output | 1 | Output residue and score are valid |
| out_res | output | 5 | Forwarded subject residue |
| out_score | output | 16 | This cell's score for the forwarded residue |
| best_score | output | 16 | Highest score in the current pass |
| active_bank | output | 1 | Index of the bank serving the current pass |
| query_res | output | 5 | Query residue of the current pass |

## Verification
Assertions are checked on every cycle for several properties. An idle cycle must freeze the score and best registers. The output must appear only one cycle after an accepted residue and must carry that residue forward. `best_score` must never fall inside a pass and must never lie below a valid output. Each pass boundary must toggle the bank and empty the best score. A write must land only in the idle bank.

Only the bench's scenarios can show the values themselves. These cover the four-way maximum and the left and diagonal chains, saturation near 65535, and out-of-range residue codes. They also show that the gap penalty changes at run time and that a column written into the idle bank during a pass leaves that pass's results untouched and then serves the next pass.

// File: rtl/sw_cell_pkg.sv
package sw_cell_pkg;
  localparam int RES_W   = 5;
  localparam int ALPHA   = 24;
  localparam int SUB_W   = 8;
  localparam int SCORE_W = 16;
  localparam int GAP_W   = 8;
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sw_score_bank.sv
module sw_score_bank #(
  parameter int DEPTH = 24,
  parameter int RES_W = 5,
  parameter int SUB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [RES_W-1:0] wr_addr,
  input  logic [SUB_W-1:0] wr_data,
  input  logic [RES_W-1:0] rd_addr,
  output logic [SUB_W-1:0] rd_data
);
  logic [SUB_W-1:0] rd_b [2];
  logic             wr_in_range;
  logic             rd_in_range;

  assign wr_in_range = (32'(wr_addr) < DEPTH);
  assign rd_in_range = (32'(rd_addr) < DEPTH);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [SUB_W-1:0] mem [DEPTH];
    logic             bank_we;

    // only the bank not serving the current pass may be written
    assign bank_we = wr_en && wr_in_range && (sel != 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) mem[wr_addr] <= wr_data;
    end

    assign rd_b[b] = rd_in_range ? mem[rd_addr] : '0;

    // R8: a write into the idle bank is visible there on the next cycle
    a_r8_idle_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_in_range && sel != 1'(b)) |=> mem[$past(wr_addr)] == $past(wr_data));
  end

  assign rd_data = rd_b[sel];
endmodule

// File: rtl/sw_cell_calc.sv
module sw_cell_calc #(
  parameter int SCORE_W = 16,
  parameter int SUB_W   = 8,
  parameter int GAP_W   = 8
) (
  input  logic [SCORE_W-1:0] diag,
  input  logic [SCORE_W-1:0] up,
  input  logic [SCORE_W-1:0] left,
  input  logic [SUB_W-1:0]   sub,
  input  logic [GAP_W-1:0]   gap,
  output logic [SCORE_W-1:0] score
);
  localparam int EXT_W = SCORE_W + 2;
  localparam logic [SCORE_W-1:0] SCORE_MAX = {SCORE_W{1'b1}};

  logic signed [EXT_W-1:0] diag_sum;
  logic [SCORE_W-1:0]      gap_ext;
  logic [SCORE_W-1:0]      diag_t;
  logic [SCORE_W-1:0]      up_t;
  logic [SCORE_W-1:0]      left_t;
  logic [SCORE_W-1:0]      best_a;
  logic [SCORE_W-1:0]      best_b;

  assign gap_ext  = SCORE_W'(gap);
  assign diag_sum = $signed({2'b00, diag}) + $signed({{(EXT_W-SUB_W){sub[SUB_W-1]}}, sub});

  always_comb begin
    if (diag_sum < 0)
      diag_t = '0;
    else if (diag_sum > $signed({2'b00, SCORE_MAX}))
      diag_t = SCORE_MAX;
    else
      diag_t = diag_sum[SCORE_W-1:0];

    up_t   = (up   > gap_ext) ? (up   - gap_ext) : '0;
    left_t = (left > gap_ext) ? (left - gap_ext) : '0;

    best_a = (diag_t > up_t)   ? diag_t : up_t;
    best_b = (left_t > best_a) ? left_t : best_a;
    score  = best_b;
  end
endmodule

// File: rtl/sw_cell.sv
module sw_cell
  import sw_cell_pkg::*;
#(
  parameter int P_RES_W   = RES_W,
  parameter int P_ALPHA   = ALPHA,
  parameter int P_SUB_W   = SUB_W,
  parameter int P_SCORE_W = SCORE_W,
  parameter int P_GAP_W   = GAP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pass_start,
  input  logic [P_GAP_W-1:0]   gap_pen,
  input  logic                 qry_we,
  input  logic [P_RES_W-1:0]   qry_in,
  input  logic                 cfg_we,
  input  logic [P_RES_W-1:0]   cfg_addr,
  input  logic [P_SUB_W-1:0]   cfg_data,
  input  logic                 in_valid,
  input  logic [P_RES_W-1:0]   in_res,
  input  logic [P_SCORE_W-1:0] in_score,
  output logic                 out_valid,
  output logic [P_RES_W-1:0]   out_res,
  output logic [P_SCORE_W-1:0] out_score,
  output logic [P_SCORE_W-1:0] best_score,
  output logic                 active_bank,
  output logic [P_RES_W-1:0]   query_res
);
  logic                 rs_n;
  logic                 act_q,   act_d;
  logic [P_RES_W-1:0]   qst_q,   qst_d;
  logic [P_RES_W-1:0]   qact_q,  qact_d;
  logic [P_SCORE_W-1:0] left_q,  left_d;
  logic [P_SCORE_W-1:0] diag_q,  diag_d;
  logic [P_SCORE_W-1:0] best_q,  best_d;
  logic [P_SCORE_W-1:0] osc_q,   osc_d;
  logic [P_RES_W-1:0]   ores_q,  ores_d;
  logic                 ov_q,    ov_d;
  logic [P_SUB_W-1:0]   sub_score;
  logic [P_SCORE_W-1:0] cell_score;
  logic                 advance;

  sw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rs_n)
  );

  sw_score_bank #(
    .DEPTH (P_ALPHA),
    .RES_W (P_RES_W),
    .SUB_W (P_SUB_W)
  ) u_banks (
    .clk     (clk),
    .rst_n   (rs_n),
    .sel     (act_q),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .rd_addr (in_res),
    .rd_data (sub_score)
  );

  sw_cell_calc #(
    .SCORE_W (P_SCORE_W),
    .SUB_W   (P_SUB_W),
    .GAP_W   (P_GAP_W)
  ) u_calc (
    .diag  (diag_q),
    .up    (in_score),
    .left  (left_q),
    .sub   (sub_score),
    .gap   (gap_pen),
    .score (cell_score)
  );

  // clock enable for the scoring registers
  assign advance = in_valid && !pass_start;

  always_comb begin
    act_d  = act_q;
    qact_d = qact_q;
    qst_d  = qry_we ? qry_in : qst_q;
    left_d = left_q;
    diag_d = diag_q;
    best_d = best_q;
    osc_d  = osc_q;
    ores_d = ores_q;
    ov_d   = 1'b0;
    if (pass_start) begin
      act_d  = ~act_q;
      qact_d = qst_q;
      left_d = '0;
      diag_d = '0;
      best_d = '0;
    end else if (advance) begin
      ov_d   = 1'b1;
      ores_d = in_res;
      osc_d  = cell_score;
      left_d = cell_score;
      diag_d = in_score;
      best_d = (cell_score > best_q) ? cell_score : best_q;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      act_q  <= 1'b0;
      qst_q  <= '0;
      qact_q <= '0;
      left_q <= '0;
      diag_q <= '0;
      best_q <= '0;
      osc_q  <= '0;
      ores_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      qst_q  <= qst_d;
      qact_q <= qact_d;
      left_q <= left_d;
      diag_q <= diag_d;
      best_q <= best_d;
      osc_q  <= osc_d;
      ores_q <= ores_d;
      ov_q   <= ov_d;
    end
  end

  assign out_valid   = ov_q;
  assign out_res     = ores_q;
  assign out_score   = osc_q;
  assign best_score  = best_q;
  assign active_bank = act_q;
  assign query_res   = qact_q;

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rs_n)
    (!in_valid && !pass_start) |=> ($stable(out_score) && $stable(best_score) && $stable(out_res) && !out_valid));

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rs_n)
    out_valid |-> ($past(in_valid && !pass_start) && out_res == $past(in_res)));

  a_r10_best_covers_out: assert property (@(posedge clk) disable iff (!rs_n)
    out_valid |-> (best_score >= out_score));

  a_r10_best_monotone: assert property (@(posedge clk) disable iff (!rs_n)
    !pass_start |=> (best_score >= $past(best_score)));

  a_r9_swap_clears: assert property (@(posedge clk) disable iff (!rs_n)
    pass_start |=> (active_bank != $past(active_bank) && best_score == '0 && !out_valid));
endmodule

// File: tb/sw_cell_tb.sv
module sw_cell_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pass_start;
  logic [7:0]  gap_pen;
  logic        qry_we;
  logic [4:0]  qry_in;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic        in_valid;
  logic [4:0]  in_res;
  logic [15:0] in_score;
  logic        out_valid;
  logic [4:0]  out_res;
  logic [15:0] out_score;
  logic [15:0] best_score;
  logic        active_bank;
  logic [4:0]  query_res;

  always #10 clk = ~clk;

  sw_cell u_dut (
    .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .gap_pen(gap_pen),
    .qry_we(qry_we), .qry_in(qry_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_res(in_res), .in_score(in_score),
    .out_valid(out_valid), .out_res(out_res), .out_score(out_score),
    .best_score(best_score), .active_bank(active_bank), .query_res(query_res)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural reference state
  int bank [2][24];
  int m_act = 0, m_qst = 0, m_qact = 0, m_left = 0, m_diag = 0, m_best = 0;
  int m_ov = 0, m_ores = 0, m_osc = 0;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // apply current inputs to the model, clock once, compare outputs
  task automatic tick(string tag);
    int sub, d, u, l, f, wb;
    wb = 1 - m_act;
    if (pass_start) begin
      m_act = 1 - m_act; m_qact = m_qst;
      m_left = 0; m_diag = 0; m_best = 0; m_ov = 0;
    end else if (in_valid) begin
      sub = (in_res < 24) ? bank[m_act][in_res] : 0;
      d = m_diag + sub; if (d < 0) d = 0; if (d > 65535) d = 65535;
      u = int'(in_score) - int'(gap_pen); if (u < 0) u = 0;
      l = m_left - int'(gap_pen); if (l < 0) l = 0;
      f = d; if (u > f) f = u; if (l > f) f = l;
      m_ov = 1; m_ores = in_res; m_osc = f;
      m_left = f; m_diag = in_score;
      if (f > m_best) m_best = f;
    end else begin
      m_ov = 0;
    end
    if (cfg_we && cfg_addr < 24) bank[wb][cfg_addr] = int'($signed(cfg_data));
    if (qry_we) m_qst = qry_in;
    @(posedge clk);
    @(negedge clk);
    chk("R7", out_valid, m_ov);
    if (m_ov) begin
      chk("R5", out_res, m_ores);
      chk(tag, out_score, m_osc);
    end
    chk("R10", best_score, m_best);
    chk("R9", active_bank, m_act);
    chk("R9", query_res, m_qact);
  endtask

  task automatic clear_in();
    pass_start = 0; qry_we = 0; cfg_we = 0; in_valid = 0;
  endtask

  task automatic wr(int a, int v, string tag);
    cfg_we = 1; cfg_addr = 5'(a); cfg_data = 8'(v);
    tick(tag);
    cfg_we = 0;
  endtask

  task automatic feed(int r, int s, string tag);
    in_valid = 1; in_res = 5'(r); in_score = 16'(s);
    tick(tag);
    in_valid = 0;
  endtask

  task automatic new_pass(string tag);
    pass_start = 1;
    tick(tag);
    pass_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; clear_in();
    gap_pen = 8'd3; qry_in = '0; cfg_addr = '0; cfg_data = '0; in_res = '0; in_score = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", out_valid, 0); chk("R1", out_score, 0); chk("R1", best_score, 0);
    chk("R1", active_bank, 0); chk("R1", query_res, 0);

    // load a column into the idle bank (bank 1) and stage query 3
    for (int a = 0; a < 24; a++) wr(a, ((a * 5) % 11) - 4, "R8");
    wr(25, 99, "R8");
    qry_in = 5'd3; qry_we = 1; tick("R9"); qry_we = 0;
    new_pass("R9");

    // compute while writing the next column (all 127) into bank 0
    for (int j = 0; j < 24; j++) begin
      cfg_we = 1; cfg_addr = 5'(j); cfg_data = 8'd127;
      feed((j * 7) % 24, (j * 13) % 40, "R2");
      cfg_we = 0;
    end
    // idle cycles with a changed penalty
    gap_pen = 8'd200; tick("R7"); tick("R7");
    gap_pen = 8'd10;
    for (int r = 24; r < 32; r++) feed(r, 5 + r, "R3");
    feed(1, 60, "R11");
    gap_pen = 8'd0;
    feed(2, 0, "R11");
    gap_pen = 8'd2;
    feed(4, 50, "R6"); feed(4, 0, "R6"); feed(9, 0, "R6");

    // pass boundary with a residue offered in the same cycle (dropped)
    qry_in = 5'd17; qry_we = 1; tick("R9"); qry_we = 0;
    in_valid = 1; in_res = 5'd5; in_score = 16'd500;
    new_pass("R9");
    in_valid = 0;
    feed(0, 0, "R6");

    // saturation with the all-127 column
    gap_pen = 8'd1;
    feed(3, 65530, "R4"); feed(3, 65535, "R4"); feed(8, 65535, "R4");
    for (int k = 0; k < 5; k++) feed(23, 0, "R6");

    // overlap: write a new column while computing, then check it serves the next pass
    for (int j = 0; j < 24; j++) begin
      cfg_we = 1; cfg_addr = 5'(j); cfg_data = 8'(-(j % 7));
      feed(j, 100 + j, "R8");
      cfg_we = 0;
    end
    new_pass("R9");
    for (int j = 0; j < 10; j++) feed((j * 5) % 24, 200 - j * 11, "R2");
    summary();
  end
endmodule